// File: doc/BRIEF.md
# Dual-Thread In-Order Group Dispatcher

This block sits between two per-thread instruction buffers and the execution units of an in-order superscalar core that runs two hardware threads. Each cycle it looks at the oldest instructions of each thread's buffer, forms the largest legal group from them in program order, and issues that group as a single unit. A group is bounded in total size and in per-class unit usage. It is also cut short by a dependency on an earlier member of the same group, or by a dedicated no-op that ends a group. A group issues only once every source operand of every member is ready. Nothing inside a group goes ahead of the others.

Readiness comes from a per-thread scoreboard. Each architectural register has a countdown counter. An issuing producer loads its destination counter from the latency of its unit class, and a source is ready when its counter reads zero. The threads take turns owning the dispatch slot. If the owning thread has nothing ready, the other thread may use the slot. Buffers keep their instructions until the group that holds them issues, and the block reports how many entries each buffer may drop.

Each instruction is a 20-bit word: bit 19 is the group-end flag, bits 18:16 the unit class (0 fixed-point, 1 load/store, 2 floating-point, 3 branch, 4 vector; 5 to 7 are treated as vector), bit 15 the register-write enable, bits 14:10 the destination register, bits 9:5 the first source and bits 4:0 the second source. Buffer slot 0 of each window is the oldest instruction.

Top module: `grp_dispatch`

## Requirements
- R1: While rst_n is low no group is issued and both pop counts are zero. Reset clears every scoreboard counter, and thread 0 owns the first cycle after reset.
- R2: A group holds at most 5 instructions. It is the longest run of valid window slots, taken from slot 0 upward, that breaks none of the rules below.
- R3: A group holds at most 2 fixed-point, 2 load/store, 2 floating-point, 1 branch and 1 vector instruction. An instruction that would exceed its class limit closes the group before itself.
- R4: An instruction with the group-end flag (bit 19) joins the current group and closes it after itself. It uses no class budget, writes no register and is not checked for operand readiness.
- R5: An instruction that reads (bits 9:5 or 4:0) a register written by an earlier member of the same group closes the group before itself.
- R6: A group issues only when no source register of any non-flagged member has a nonzero counter in its thread's scoreboard. Otherwise the whole group waits and no part of it issues.
- R7: A dependent instruction can issue at the earliest 1 cycle after a fixed-point producer, 3 cycles after a load/store producer and 6 cycles after a floating-point producer, and also 1 cycle after a branch and 6 after a vector producer. Within one group, the last writer of a register sets its counter.
- R8: Ownership of the dispatch slot alternates between the threads every cycle, whether or not anything issues.
- R9: If the owning thread has no group that can issue, the other thread issues its group when that group is ready. If neither can issue, nothing issues.
- R10: An issued group shows its instructions in output slots 0 upward, with contiguous valid bits and unused slots zero. The issuing thread's pop count equals the group size, and the other thread's pop count is zero.
- R11: Each thread has its own scoreboard. A pending result in one thread never stalls the other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_vld | input | 5 | Valid bits of thread 0 buffer window, slot 0 oldest |
| t0_ins | input | 100 | Thread 0 window, slot i at bits 20*i+19 : 20*i |
| t1_vld | input | 5 | Valid bits of thread 1 buffer window |
| t1_ins | input | 100 | Thread 1 window |
| t0_pop | output | 3 | Entries thread 0 buffer drops this cycle |
| t1_pop | output | 3 | Entries thread 1 buffer drops this cycle |
| d_vld | output | 1 | A group issues this cycle |
| d_tid | output | 1 | Thread of the issued group, zero when idle |
| d_slot_vld | output | 5 | Valid bit per issued slot |
| d_ins | output | 100 | Issued instructions, zero in unused slots |

## Verification
On every cycle the assertions check the shape of whatever issues. Class counts stay within their limits, a flagged instruction is always last, no member reads a register that an earlier member writes, and every source of an issued member has a zero counter. Slot valid bits are contiguous and the pop counts match them. Only the bench's reference model can show that the group is as long as the rules allow, and that stalls last exactly the producer latency and no longer. The model also shows the turn order between threads, the takeover of an idle slot by the other thread, and that each thread's scoreboard does not affect the other thread.

// File: rtl/grp_dispatch.sv
module grp_dispatch #(
  parameter int W       = 5,
  parameter int NREG    = 32,
  parameter int FX_LAT  = 1,
  parameter int LD_LAT  = 3,
  parameter int FP_LAT  = 6,
  parameter int BR_LAT  = 1,
  parameter int VEC_LAT = 6,
  parameter int MAX_FX  = 2,
  parameter int MAX_LS  = 2,
  parameter int MAX_FP  = 2,
  parameter int MAX_BR  = 1,
  parameter int MAX_VEC = 1,
  localparam int RW     = $clog2(NREG),
  localparam int IW     = 5 + 3 * RW,
  localparam int PW     = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    t0_vld,
  input  logic [W*IW-1:0] t0_ins,
  input  logic [W-1:0]    t1_vld,
  input  logic [W*IW-1:0] t1_ins,
  output logic [PW-1:0]   t0_pop,
  output logic [PW-1:0]   t1_pop,
  output logic            d_vld,
  output logic            d_tid,
  output logic [W-1:0]    d_slot_vld,
  output logic [W*IW-1:0] d_ins
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXL = mx(mx(mx(FX_LAT, LD_LAT), mx(FP_LAT, BR_LAT)), VEC_LAT);
  localparam int CNTW = $clog2(MAXL + 1);

  function automatic logic f_term(input logic [IW-1:0] x);
    return x[IW-1];
  endfunction
  function automatic logic [2:0] f_cls(input logic [IW-1:0] x);
    return x[IW-2 -: 3];
  endfunction
  function automatic logic f_we(input logic [IW-1:0] x);
    return x[3*RW];
  endfunction
  function automatic logic [RW-1:0] f_dst(input logic [IW-1:0] x);
    return x[3*RW-1 -: RW];
  endfunction
  function automatic logic [RW-1:0] f_sa(input logic [IW-1:0] x);
    return x[2*RW-1 -: RW];
  endfunction
  function automatic logic [RW-1:0] f_sb(input logic [IW-1:0] x);
    return x[RW-1:0];
  endfunction

  function automatic logic [CNTW-1:0] lat1(input logic [2:0] c);
    case (c)
      3'd0:    return CNTW'(FX_LAT - 1);
      3'd1:    return CNTW'(LD_LAT - 1);
      3'd2:    return CNTW'(FP_LAT - 1);
      3'd3:    return CNTW'(BR_LAT - 1);
      default: return CNTW'(VEC_LAT - 1);
    endcase
  endfunction

  function automatic logic [PW:0] form(input logic [W-1:0] v, input logic [W*IW-1:0] fl,
                                       input logic [NREG-1:0] bz);
    int nfx, nls, nfp, nbr, nvx;
    logic open, rdy, full;
    logic [NREG-1:0] wr;
    logic [PW-1:0] n;
    logic [IW-1:0] x;
    nfx = 0; nls = 0; nfp = 0; nbr = 0; nvx = 0;
    open = 1'b1; rdy = 1'b1; wr = '0; n = '0;
    for (int i = 0; i < W; i++) begin
      x = fl[i*IW +: IW];
      case (f_cls(x))
        3'd0:    full = (nfx >= MAX_FX);
        3'd1:    full = (nls >= MAX_LS);
        3'd2:    full = (nfp >= MAX_FP);
        3'd3:    full = (nbr >= MAX_BR);
        default: full = (nvx >= MAX_VEC);
      endcase
      if (f_term(x)) full = 1'b0;
      else if (wr[f_sa(x)] || wr[f_sb(x)]) full = 1'b1;
      if (open && v[i] && !full) begin
        n = n + 1'b1;
        if (f_term(x)) open = 1'b0;
        else begin
          case (f_cls(x))
            3'd0:    nfx++;
            3'd1:    nls++;
            3'd2:    nfp++;
            3'd3:    nbr++;
            default: nvx++;
          endcase
          if (bz[f_sa(x)] || bz[f_sb(x)]) rdy = 1'b0;
          if (f_we(x)) wr[f_dst(x)] = 1'b1;
        end
      end else begin
        open = 1'b0;
      end
    end
    return {rdy && (n != '0), n};
  endfunction

  logic                turn;
  logic [CNTW-1:0]     cnt [2][NREG];
  logic [NREG-1:0]     busy [2];
  logic [PW:0]         g0, g1;
  logic                rdy0, rdy1, sel;
  logic [PW-1:0]       n_sel;
  logic [NREG-1:0]     ld_en;
  logic [CNTW-1:0]     ld_val [NREG];

  always_comb
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < NREG; r++)
        busy[t][r] = (cnt[t][r] != '0);

  assign g0    = form(t0_vld, t0_ins, busy[0]);
  assign g1    = form(t1_vld, t1_ins, busy[1]);
  assign rdy0  = g0[PW];
  assign rdy1  = g1[PW];
  assign sel   = turn ? rdy1 : !rdy0;
  assign d_vld = rst_n && (rdy0 || rdy1);
  assign d_tid = d_vld && sel;
  assign n_sel = sel ? g1[PW-1:0] : g0[PW-1:0];
  assign t0_pop = (d_vld && !sel) ? g0[PW-1:0] : '0;
  assign t1_pop = (d_vld && sel)  ? g1[PW-1:0] : '0;

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign d_slot_vld[i]      = d_vld && (PW'(i) < n_sel);
    assign d_ins[i*IW +: IW]  = d_slot_vld[i] ? (sel ? t1_ins[i*IW +: IW] : t0_ins[i*IW +: IW]) : '0;
  end

  always_comb begin
    ld_en = '0;
    for (int r = 0; r < NREG; r++) ld_val[r] = '0;
    for (int i = 0; i < W; i++)
      if (d_slot_vld[i] && !f_term(d_ins[i*IW +: IW]) && f_we(d_ins[i*IW +: IW])) begin
        ld_en[f_dst(d_ins[i*IW +: IW])]  = 1'b1;
        ld_val[f_dst(d_ins[i*IW +: IW])] = lat1(f_cls(d_ins[i*IW +: IW]));
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn <= 1'b0;
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < NREG; r++)
          cnt[t][r] <= '0;
    end else begin
      turn <= ~turn;
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < NREG; r++)
          if (d_vld && (sel == (t == 1)) && ld_en[r]) cnt[t][r] <= ld_val[r];
          else if (cnt[t][r] != '0) cnt[t][r] <= cnt[t][r] - 1'b1;
    end
  end

  logic [W-1:0]    is_fx, is_ls, is_fp, is_br, is_vx, is_tm;
  logic [NREG-1:0] busy_sel;
  assign busy_sel = d_tid ? busy[1] : busy[0];

  always_comb
    for (int i = 0; i < W; i++) begin
      is_tm[i] = d_slot_vld[i] && f_term(d_ins[i*IW +: IW]);
      is_fx[i] = d_slot_vld[i] && !is_tm[i] && f_cls(d_ins[i*IW +: IW]) == 3'd0;
      is_ls[i] = d_slot_vld[i] && !is_tm[i] && f_cls(d_ins[i*IW +: IW]) == 3'd1;
      is_fp[i] = d_slot_vld[i] && !is_tm[i] && f_cls(d_ins[i*IW +: IW]) == 3'd2;
      is_br[i] = d_slot_vld[i] && !is_tm[i] && f_cls(d_ins[i*IW +: IW]) == 3'd3;
      is_vx[i] = d_slot_vld[i] && !is_tm[i] && f_cls(d_ins[i*IW +: IW]) > 3'd3;
    end

  p_class_caps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_fx) <= MAX_FX && $countones(is_ls) <= MAX_LS && $countones(is_fp) <= MAX_FP &&
    $countones(is_br) <= MAX_BR && $countones(is_vx) <= MAX_VEC);

  p_contig_slots_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld |-> d_slot_vld[0] && ((d_slot_vld & W'(d_slot_vld + 1'b1)) == '0));

  p_pop_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld |-> (t0_pop == '0 || t1_pop == '0) && int'(t0_pop | t1_pop) == $countones(d_slot_vld));

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_src_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_slot_vld[i] && !is_tm[i]) |->
        !busy_sel[f_sa(d_ins[i*IW +: IW])] && !busy_sel[f_sb(d_ins[i*IW +: IW])]);
    if (i < W - 1) begin : g_last
      p_term_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_tm[i] |-> !d_slot_vld[i+1]);
    end
    for (genvar j = i + 1; j < W; j++) begin : g_pair
      p_no_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_slot_vld[j] && !is_tm[j] && d_slot_vld[i] && !is_tm[i] && f_we(d_ins[i*IW +: IW])) |->
          f_dst(d_ins[i*IW +: IW]) != f_sa(d_ins[j*IW +: IW]) &&
          f_dst(d_ins[i*IW +: IW]) != f_sb(d_ins[j*IW +: IW]));
    end
  end

endmodule

// File: tb/grp_dispatch_tb.sv
module grp_dispatch_tb;
  localparam int W = 5, IW = 20, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] t0_vld, t1_vld, d_slot_vld;
  logic [W*IW-1:0] t0_ins, t1_ins, d_ins;
  logic [PW-1:0] t0_pop, t1_pop;
  logic d_vld, d_tid;

  grp_dispatch u_dut (.clk(clk), .rst_n(rst_n), .t0_vld(t0_vld), .t0_ins(t0_ins),
    .t1_vld(t1_vld), .t1_ins(t1_ins), .t0_pop(t0_pop), .t1_pop(t1_pop),
    .d_vld(d_vld), .d_tid(d_tid), .d_slot_vld(d_slot_vld), .d_ins(d_ins));

  logic [IW-1:0] q0[$], q1[$];
  int sb[2][32];
  int turn_m = 0;
  int checks = 0, errors = 0;
  string tag = "R1";

  function automatic logic [IW-1:0] mk(bit term, int cls, bit we, int d, int a, int b);
    return {term, cls[2:0], we, d[4:0], a[4:0], b[4:0]};
  endfunction
  function automatic int lat(int c);
    case (c) 0: return 1; 1: return 3; 2: return 6; 3: return 1; default: return 6; endcase
  endfunction
  function automatic int cap(int c);
    return (c < 3) ? 2 : 1;
  endfunction
  function automatic int qsize(int t);
    return t ? q1.size() : q0.size();
  endfunction
  function automatic logic [IW-1:0] qget(int t, int k);
    return t ? q1[k] : q0[k];
  endfunction

  task automatic form_m(input int t, output int n, output bit rdy);
    int used[5];
    bit wr[32];
    logic [IW-1:0] x;
    int c;
    foreach (used[k]) used[k] = 0;
    foreach (wr[k]) wr[k] = 0;
    n = 0; rdy = 1;
    while (n < W && n < qsize(t)) begin
      x = qget(t, n);
      if (x[19]) begin n++; break; end
      c = int'(x[18:16]);
      if (used[c] >= cap(c)) break;
      if (wr[x[9:5]] || wr[x[4:0]]) break;
      if (sb[t][x[9:5]] != 0 || sb[t][x[4:0]] != 0) rdy = 0;
      used[c]++;
      if (x[15]) wr[x[14:10]] = 1;
      n++;
    end
    rdy = rdy && (n > 0);
  endtask

  task automatic check(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int n0, n1, en, et;
    bit r0, r1, ev;
    logic [W-1:0] emask;
    logic [W*IW-1:0] eins;
    logic [IW-1:0] x;
    for (int i = 0; i < W; i++) begin
      t0_vld[i] = (i < q0.size());
      t1_vld[i] = (i < q1.size());
      t0_ins[i*IW +: IW] = (i < q0.size()) ? q0[i] : '0;
      t1_ins[i*IW +: IW] = (i < q1.size()) ? q1[i] : '0;
    end
    #1;
    form_m(0, n0, r0);
    form_m(1, n1, r1);
    ev = rst_n && (r0 || r1);
    et = turn_m ? (r1 ? 1 : 0) : (r0 ? 0 : 1);
    en = ev ? (et ? n1 : n0) : 0;
    if (!ev) et = 0;
    emask = '0; eins = '0;
    for (int i = 0; i < en; i++) begin
      emask[i] = 1'b1;
      eins[i*IW +: IW] = qget(et, i);
    end
    check("group", {d_vld, d_vld & d_tid, d_slot_vld}, {ev, et[0], emask});
    check("pops", {t0_pop, t1_pop}, {(ev && et == 0) ? PW'(en) : PW'(0), (ev && et == 1) ? PW'(en) : PW'(0)});
    check("slots", d_ins, eins);
    if (rst_n) begin
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 32; r++)
          if (sb[t][r] > 0) sb[t][r]--;
      for (int i = 0; i < en; i++) begin
        x = qget(et, i);
        if (!x[19] && x[15]) sb[et][x[14:10]] = lat(int'(x[18:16])) - 1;
      end
      for (int i = 0; i < en; i++) begin
        if (et == 1) void'(q1.pop_front());
        else void'(q0.pop_front());
      end
      turn_m ^= 1;
    end
    @(negedge clk);
  endtask

  task automatic drain(string s);
    tag = s;
    for (int k = 0; k < 200 && (q0.size() > 0 || q1.size() > 0); k++) step();
    repeat (8) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (sb[t, r]) sb[t][r] = 0;
    @(negedge clk);
    // R1: held in reset with work pending, then thread 0 goes first
    q0.push_back(mk(0, 0, 1, 2, 0, 0));
    q1.push_back(mk(0, 0, 1, 3, 0, 0));
    tag = "R1 reset idle";
    step(); step();
    rst_n = 1'b1;
    drain("R1 R8 first owner after reset");

    // R2 R3: five-slot cap and class caps
    q0.push_back(mk(0, 0, 1, 10, 0, 0)); q0.push_back(mk(0, 0, 1, 11, 0, 0));
    q0.push_back(mk(0, 1, 1, 12, 0, 0)); q0.push_back(mk(0, 1, 0, 0, 0, 0));
    q0.push_back(mk(0, 2, 1, 13, 0, 0)); q0.push_back(mk(0, 2, 1, 14, 0, 0));
    q0.push_back(mk(0, 3, 0, 0, 0, 0));  q0.push_back(mk(0, 3, 0, 0, 0, 0));
    q0.push_back(mk(0, 0, 1, 15, 0, 0)); q0.push_back(mk(0, 0, 1, 16, 0, 0));
    q0.push_back(mk(0, 0, 1, 17, 0, 0)); q0.push_back(mk(0, 4, 1, 18, 0, 0));
    q0.push_back(mk(0, 4, 1, 19, 0, 0));
    drain("R2 R3 size and class caps");

    // R4: group-end flag
    q0.push_back(mk(0, 0, 1, 2, 0, 0)); q0.push_back(mk(1, 0, 0, 1, 1, 0));
    q0.push_back(mk(0, 0, 1, 4, 2, 0)); q0.push_back(mk(1, 0, 0, 1, 1, 0));
    q0.push_back(mk(1, 0, 0, 1, 1, 0));
    drain("R4 group end flag");

    // R5: dependency inside the window
    q1.push_back(mk(0, 1, 1, 3, 0, 0)); q1.push_back(mk(0, 0, 1, 4, 0, 3));
    q1.push_back(mk(0, 2, 1, 5, 0, 0)); q1.push_back(mk(0, 2, 1, 6, 5, 0));
    drain("R5 intra group raw");

    // R6 R7: whole-group stall and per-class latency
    q0.push_back(mk(0, 2, 1, 7, 0, 0)); q0.push_back(mk(1, 0, 0, 1, 1, 0));
    q0.push_back(mk(0, 0, 1, 8, 0, 0)); q0.push_back(mk(0, 2, 1, 9, 7, 0));
    drain("R6 R7 fp latency whole group");
    q0.push_back(mk(0, 1, 1, 7, 0, 0)); q0.push_back(mk(1, 0, 0, 1, 1, 0));
    q0.push_back(mk(0, 0, 1, 8, 0, 7));
    q0.push_back(mk(0, 0, 1, 9, 0, 0)); q0.push_back(mk(1, 0, 0, 1, 1, 0));
    q0.push_back(mk(0, 0, 1, 10, 9, 9));
    q0.push_back(mk(0, 4, 1, 11, 0, 0)); q0.push_back(mk(0, 0, 1, 12, 0, 0));
    q0.push_back(mk(0, 0, 1, 12, 0, 0)); q0.push_back(mk(1, 0, 0, 1, 1, 0));
    q0.push_back(mk(0, 4, 1, 13, 11, 12));
    drain("R7 load fx vector latency and last writer");

    // R8 R9 R11: alternation, slot takeover, separate scoreboards
    for (int k = 0; k < 6; k++) begin
      q0.push_back(mk(0, 0, 1, 20 + k, 0, 0));
      q1.push_back(mk(0, 0, 1, 20 + k, 0, 0));
      q0.push_back(mk(1, 0, 0, 1, 1, 0));
      q1.push_back(mk(1, 0, 0, 1, 1, 0));
    end
    drain("R8 alternation");
    q1.push_back(mk(0, 2, 1, 5, 0, 0)); q1.push_back(mk(1, 0, 0, 1, 1, 0));
    q1.push_back(mk(0, 2, 1, 6, 5, 0));
    for (int k = 0; k < 8; k++) begin
      q0.push_back(mk(0, 0, 1, 6, 5, 5));
      q0.push_back(mk(1, 0, 0, 1, 1, 0));
    end
    drain("R9 R11 takeover and separate scoreboards");

    // R10 and all rules under mixed random traffic
    tag = "R10 mixed traffic";
    for (int c = 0; c < 3000; c++) begin
      for (int t = 0; t < 2; t++)
        while (qsize(t) < 8 && $urandom_range(0, 3) != 0) begin
          automatic int cl = $urandom_range(0, 4);
          automatic logic [IW-1:0] x = ($urandom_range(0, 11) == 0) ? mk(1, 0, 0, 1, 1, 0) :
            mk(0, cl, (cl != 3), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
          if (t == 1) q1.push_back(x); else q0.push_back(x);
        end
      step();
    end
    drain("R10 mixed traffic drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule